// File: doc/BRIEF.md
# Card Status-Change Interrupt Controller

This block sits beside a removable-card socket and turns activity on five card status lines into a host interrupt. The lines are card detect, write protect, ready, and two battery-low levels. Each line is synchronised, compared with its previous sample, and any change on a line that is not masked raises the card-status-change cause in an interrupt status register. Software can also set other causes in that register. It can set, clear or reload any of them through a control encoding carried in the low two bits of each write.

An enable register selects which causes may assert the interrupt. Its two low bits choose how the interrupt pin is driven: floating, open drain active low, driven active low, or driven active high. The pin is presented as a drive-enable and a level so that the board pad can be built outside the block. A control register holds a socket-enable bit, an auto-busy bit and an access flag. The access flag is set whenever the card data path reports an access. These three bits decide the busy indicator.

The host uses a small synchronous register port. Writes take effect on the clock edge. Reads are combinational from the current register state.

Top module: `card_evt_irq`

## Requirements
- R1: After reset every register reads 0x00, the pin drive-enable is low and the busy indicator is low.
- R2: Address 0 returns the synchronised status lines: card detect in bit 7, write protect in bit 6, ready in bit 5, battery-low 2 in bit 4, battery-low 1 in bit 3, and zero in bits 2:0. A line change is visible two clock edges after it is applied.
- R3: A change on an unmasked line sets bit 6 of the interrupt status register (address 1) on the third edge after the change. For the ready line both rising and falling edges count. A change has priority over a software clear on the same edge.
- R4: The mask register (address 3) uses the bit positions of R2. A set mask bit stops changes on that line from setting bit 6, and mask bits 2:0 read zero.
- R5: Writes to address 1 act on bits 7:2 according to data bits 1:0. 2'b10 sets the bits marked 1, 2'b01 clears the bits marked 1, 2'b11 loads the data, and 2'b00 leaves the register unchanged. Bits 1:0 read zero.
- R6: The enable register (address 2) keeps bits 6:3 and 1:0, and bits 7 and 2 read zero. The interrupt is active when some bit among 6:3 is set both in the status register and in the enable register. Status bits 7 and 2 never activate it.
- R7: Enable bits 1:0 select the pin mode. 0 means the drive-enable is always low. 1 means the drive-enable equals active and the level is low. 2 means the drive-enable is high and the level is the inverse of active. 3 means the drive-enable is high and the level equals active.
- R8: Address 4 returns a latched copy of the status lines in the layout of R2, one edge after the raw value.
- R9: Address 5 holds socket-enable in bit 0, auto-busy in bit 1 and the access flag in bit 2. A card-access pulse sets the flag. A write to address 5 with bit 2 at zero clears the flag, and a write with bit 2 at one leaves it as it was.
- R10: The busy indicator equals the access flag when auto-busy is set, and equals socket-enable otherwise.
- R11: Addresses 6 and 7 read zero. Writes to them, and to the read-only addresses 0 and 4, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| statusIn | input | 5 | Status lines {card detect, write protect, ready, battery-low 2, battery-low 1} |
| cardAccess | input | 1 | Pulse from the card data path on each data access |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| irqDriveEn | output | 1 | Interrupt pad drive enable |
| irqLevel | output | 1 | Interrupt pad level when driven |
| busyLed | output | 1 | Busy indicator |

## Verification
The assertions rely on software being the only writer of the interrupt status causes other than card-status-change. They therefore treat every change in bits 7, 5:2 as coming from a register write, and they assume that regWrEn is held low while reset is applied. The stimulus keeps the status lines low through reset, drives every input at the falling clock edge, and issues one register write at a time. When it changes the status lines, it waits for the synchroniser and the edge detector to settle before it clears the status register. This way, no event lands in the middle of a software operation unless a test intends it.

// File: rtl/cevt_pkg.sv
package cevt_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_SRC = 5;
  localparam int SRC_LSB = DATA_W - NUM_SRC;   // status lines occupy the top bits
  localparam int CSC_BIT = 6;                  // card-status-change cause

  typedef enum logic [ADDR_W-1:0] {
    ADR_RAW   = 3'd0,
    ADR_ISTAT = 3'd1,
    ADR_IEN   = 3'd2,
    ADR_MASK  = 3'd3,
    ADR_LATCH = 3'd4,
    ADR_CTRL  = 3'd5
  } regAddr_e;

  // encoding follows write-data bits {set, clear}
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_JAM  = 2'd3
  } statOp_e;

  typedef enum logic [1:0] {
    PIN_OFF  = 2'd0,
    PIN_OD   = 2'd1,
    PIN_LOW  = 2'd2,
    PIN_HIGH = 2'd3
  } pinMode_e;

  typedef struct packed {
    statOp_e                statOp;
    logic                   wrEnable;
    logic                   wrMask;
    logic                   wrCtrl;
    logic [ADDR_W-1:0]      rdSel;
  } strobes_t;
endpackage

// File: rtl/cevt_ctrl.sv
module cevt_ctrl
  import cevt_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        opBits,
  output strobes_t          strobes
);
  always_comb begin
    strobes          = '0;
    strobes.statOp   = OP_NONE;
    strobes.rdSel    = regAddr;
    if (regWrEn) begin
      case (regAddr)
        ADR_ISTAT: strobes.statOp   = statOp_e'(opBits);
        ADR_IEN:   strobes.wrEnable = 1'b1;
        ADR_MASK:  strobes.wrMask   = 1'b1;
        ADR_CTRL:  strobes.wrCtrl   = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/cevt_datapath.sv
module cevt_datapath
  import cevt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] statusIn,
  input  logic               cardAccess,
  input  logic [DATA_W-1:0]  wrData,
  input  strobes_t           strobes,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqDriveEn,
  output logic               irqLevel,
  output logic               busyLed,
  output logic [DATA_W-1:0]  intStatusQ,
  output logic [1:0]         pinModeQ,
  output logic               accessQ,
  output logic               sockEnQ,
  output logic               autoBusyQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] srcHit;
  logic [7:2]         istQ;
  logic [7:2]         istNext;
  logic [6:3]         enBitsQ;
  logic               changeHit;
  logic               irqActive;
  logic               accessNext;

  // synchroniser chain and previous-sample register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], statusIn};
      prevQ <= syncQ[LAST];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcHit[i] = (syncQ[LAST][i] ^ prevQ[i]) & ~maskQ[i];
  end
  assign changeHit = |srcHit;

  // interrupt status next-state
  always_comb begin
    istNext = istQ;
    case (strobes.statOp)
      OP_SET:  istNext = istQ | wrData[7:2];
      OP_CLR:  istNext = istQ & ~wrData[7:2];
      OP_JAM:  istNext = wrData[7:2];
      default: istNext = istQ;
    endcase
    if (changeHit) istNext[CSC_BIT] = 1'b1;
  end

  always_comb begin
    accessNext = accessQ;
    if (strobes.wrCtrl) accessNext = accessQ & wrData[2];
    if (cardAccess)     accessNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istQ      <= '0;
      enBitsQ   <= '0;
      pinModeQ  <= '0;
      maskQ     <= '0;
      sockEnQ   <= 1'b0;
      autoBusyQ <= 1'b0;
      accessQ   <= 1'b0;
    end else begin
      istQ    <= istNext;
      accessQ <= accessNext;
      if (strobes.wrEnable) begin
        enBitsQ  <= wrData[6:3];
        pinModeQ <= wrData[1:0];
      end
      if (strobes.wrMask) maskQ <= wrData[DATA_W-1:SRC_LSB];
      if (strobes.wrCtrl) begin
        sockEnQ   <= wrData[0];
        autoBusyQ <= wrData[1];
      end
    end
  end

  assign irqActive = |(istQ[6:3] & enBitsQ);

  always_comb begin
    irqDriveEn = 1'b0;
    irqLevel   = 1'b0;
    case (pinMode_e'(pinModeQ))
      PIN_OD:   begin irqDriveEn = irqActive; irqLevel = 1'b0;       end
      PIN_LOW:  begin irqDriveEn = 1'b1;      irqLevel = ~irqActive; end
      PIN_HIGH: begin irqDriveEn = 1'b1;      irqLevel = irqActive;  end
      default:  begin irqDriveEn = 1'b0;      irqLevel = 1'b0;       end
    endcase
  end

  assign busyLed    = autoBusyQ ? accessQ : sockEnQ;
  assign intStatusQ = {istQ, 2'b00};

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      ADR_RAW:   rdData = {syncQ[LAST], {SRC_LSB{1'b0}}};
      ADR_ISTAT: rdData = {istQ, 2'b00};
      ADR_IEN:   rdData = {1'b0, enBitsQ, 1'b0, pinModeQ};
      ADR_MASK:  rdData = {maskQ, {SRC_LSB{1'b0}}};
      ADR_LATCH: rdData = {prevQ, {SRC_LSB{1'b0}}};
      ADR_CTRL:  rdData = {5'b0, accessQ, autoBusyQ, sockEnQ};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/card_evt_irq.sv
module card_evt_irq
  import cevt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] statusIn,
  input  logic               cardAccess,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqDriveEn,
  output logic               irqLevel,
  output logic               busyLed
);
  strobes_t          strobes;
  logic [DATA_W-1:0] intStatusQ;
  logic [1:0]        pinModeQ;
  logic              accessQ;
  logic              sockEnQ;
  logic              autoBusyQ;

  cevt_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .opBits  (regWrData[1:0]),
    .strobes (strobes)
  );

  cevt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .statusIn   (statusIn),
    .cardAccess (cardAccess),
    .wrData     (regWrData),
    .strobes    (strobes),
    .rdData     (regRdData),
    .irqDriveEn (irqDriveEn),
    .irqLevel   (irqLevel),
    .busyLed    (busyLed),
    .intStatusQ (intStatusQ),
    .pinModeQ   (pinModeQ),
    .accessQ    (accessQ),
    .sockEnQ    (sockEnQ),
    .autoBusyQ  (autoBusyQ)
  );
endmodule

// File: rtl/cevt_checker.sv
module cevt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cardAccess,
  input logic       regWrEn,
  input logic [2:0] regAddr,
  input logic [7:0] regWrData,
  input logic       irqDriveEn,
  input logic       irqLevel,
  input logic       busyLed,
  input logic [7:0] intStatusQ,
  input logic [1:0] pinModeQ,
  input logic       accessQ,
  input logic       sockEnQ,
  input logic       autoBusyQ
);
  logic statWr;
  assign statWr = regWrEn && (regAddr == 3'd1);

  a_r5_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    statWr && regWrData[1:0] == 2'b10 |=>
      (intStatusQ[7:2] & $past(regWrData[7:2])) == $past(regWrData[7:2]));

  // R5 clear, bit 6 excluded because a line change may win (R3)
  a_r5_clear_marks: assert property (@(posedge clk) disable iff (!rst_n)
    statWr && regWrData[1:0] == 2'b01 |=>
      (intStatusQ[7:2] & $past(regWrData[7:2]) & 6'b101111) == 6'b0);

  a_r5_noop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    statWr && regWrData[1:0] == 2'b00 |=>
      intStatusQ[7] == $past(intStatusQ[7]) && intStatusQ[5:2] == $past(intStatusQ[5:2]));

  a_r7_off_floats: assert property (@(posedge clk) disable iff (!rst_n)
    pinModeQ == 2'd0 |-> !irqDriveEn);

  a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    pinModeQ == 2'd1 && irqDriveEn |-> !irqLevel);

  a_r9_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cardAccess |=> accessQ);

  a_r10_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sockEnQ && !accessQ |-> !busyLed);

  a_r10_auto_gate: assert property (@(posedge clk) disable iff (!rst_n)
    autoBusyQ && !accessQ |-> !busyLed);
endmodule

bind card_evt_irq cevt_checker u_chk (.*);

// File: tb/card_evt_irq_bench.sv
module card_evt_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] statusIn = '0;
  logic       cardAccess = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqDriveEn, irqLevel, busyLed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_evt_irq u_card_evt_irq (
    .clk(clk), .rst_n(rst_n), .statusIn(statusIn), .cardAccess(cardAccess),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqDriveEn(irqDriveEn), .irqLevel(irqLevel),
    .busyLed(busyLed)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setLines(input logic [4:0] v, input int waitEdges);
    @(negedge clk);
    statusIn = v;
    repeat (waitEdges) @(negedge clk);
  endtask

  task automatic clearAll();
    wrReg(3'd1, 8'hFD);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rdReg(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset drive-enable", {7'b0, irqDriveEn}, 8'h00);
    chk("R1 reset busy", {7'b0, busyLed}, 8'h00);
  endtask

  task automatic testRaw();
    logic [7:0] d;
    setLines(5'b10110, 1);
    rdReg(3'd0, d);
    chk("R2 raw not yet visible", d, 8'h00);
    @(negedge clk);
    rdReg(3'd0, d);
    chk("R2 raw layout", d, 8'hB0);
    setLines(5'b00000, 4);
    rdReg(3'd0, d);
    chk("R2 raw back to zero", d, 8'h00);
    clearAll();
  endtask

  task automatic testEdges();
    logic [7:0] d;
    setLines(5'b00100, 2);
    rdReg(3'd1, d);
    chk("R3 not set before third edge", d, 8'h00);
    @(negedge clk);
    rdReg(3'd1, d);
    chk("R3 ready rising sets change", d, 8'h40);
    clearAll();
    rdReg(3'd1, d);
    chk("R3 cleared", d, 8'h00);
    setLines(5'b00000, 3);
    rdReg(3'd1, d);
    chk("R3 ready falling sets change", d, 8'h40);
    clearAll();
    setLines(5'b00001, 3);
    rdReg(3'd1, d);
    chk("R3 battery-low 1 sets change", d, 8'h40);
    setLines(5'b00000, 3);
    clearAll();
  endtask

  task automatic testMask();
    logic [7:0] d;
    wrReg(3'd3, 8'h20);
    setLines(5'b00100, 4);
    rdReg(3'd1, d);
    chk("R4 masked ready ignored", d, 8'h00);
    setLines(5'b10100, 3);
    rdReg(3'd1, d);
    chk("R4 unmasked card detect", d, 8'h40);
    clearAll();
    wrReg(3'd3, 8'hFF);
    rdReg(3'd3, d);
    chk("R4 mask readback", d, 8'hF8);
    setLines(5'b01011, 4);
    rdReg(3'd1, d);
    chk("R4 all masked", d, 8'h00);
    setLines(5'b00000, 4);
    wrReg(3'd3, 8'h00);
    rdReg(3'd1, d);
    chk("R4 all masked return", d, 8'h00);
  endtask

  task automatic testOps();
    logic [7:0] d;
    wrReg(3'd1, 8'hBF);
    rdReg(3'd1, d);
    chk("R5 jam", d, 8'hBC);
    wrReg(3'd1, 8'h85);
    rdReg(3'd1, d);
    chk("R5 clear", d, 8'h38);
    wrReg(3'd1, 8'h82);
    rdReg(3'd1, d);
    chk("R5 set", d, 8'hB8);
    wrReg(3'd1, 8'h44);
    rdReg(3'd1, d);
    chk("R5 neither no effect", d, 8'hB8);
    wrReg(3'd1, 8'h03);
    rdReg(3'd1, d);
    chk("R5 jam zero", d, 8'h00);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    wrReg(3'd2, 8'hFF);
    rdReg(3'd2, d);
    chk("R6 enable reserved bits zero", d, 8'h7B);
    chk("R6 idle level", {6'b0, irqDriveEn, irqLevel}, 8'h02);
    wrReg(3'd1, 8'h86);
    chk("R6 bits 7 and 2 inactive", {6'b0, irqDriveEn, irqLevel}, 8'h02);
    wrReg(3'd1, 8'h12);
    chk("R6 enabled cause active", {6'b0, irqDriveEn, irqLevel}, 8'h03);
    clearAll();
    wrReg(3'd2, 8'h23);
    wrReg(3'd1, 8'h0A);
    chk("R6 disabled cause inactive", {6'b0, irqDriveEn, irqLevel}, 8'h02);
    wrReg(3'd1, 8'h22);
    chk("R6 enabled error cause", {6'b0, irqDriveEn, irqLevel}, 8'h03);
    clearAll();
  endtask

  task automatic testPins();
    wrReg(3'd1, 8'h43);
    wrReg(3'd2, 8'h40);
    chk("R7 mode0 active", {7'b0, irqDriveEn}, 8'h00);
    wrReg(3'd2, 8'h41);
    chk("R7 mode1 active", {6'b0, irqDriveEn, irqLevel}, 8'h02);
    wrReg(3'd2, 8'h42);
    chk("R7 mode2 active", {6'b0, irqDriveEn, irqLevel}, 8'h02);
    wrReg(3'd2, 8'h43);
    chk("R7 mode3 active", {6'b0, irqDriveEn, irqLevel}, 8'h03);
    clearAll();
    chk("R7 mode3 idle", {6'b0, irqDriveEn, irqLevel}, 8'h02);
    wrReg(3'd2, 8'h42);
    chk("R7 mode2 idle", {6'b0, irqDriveEn, irqLevel}, 8'h03);
    wrReg(3'd2, 8'h41);
    chk("R7 mode1 idle floats", {7'b0, irqDriveEn}, 8'h00);
    wrReg(3'd2, 8'h40);
    chk("R7 mode0 idle", {7'b0, irqDriveEn}, 8'h00);
    wrReg(3'd2, 8'h00);
  endtask

  task automatic testLatched();
    logic [7:0] d;
    setLines(5'b01011, 2);
    rdReg(3'd0, d);
    chk("R8 raw first", d, 8'h58);
    rdReg(3'd4, d);
    chk("R8 latched lags", d, 8'h00);
    @(negedge clk);
    rdReg(3'd4, d);
    chk("R8 latched layout", d, 8'h58);
    setLines(5'b00000, 4);
    clearAll();
  endtask

  task automatic pulseAccess();
    @(negedge clk);
    cardAccess = 1'b1;
    @(negedge clk);
    cardAccess = 1'b0;
  endtask

  task automatic testAccess();
    logic [7:0] d;
    wrReg(3'd5, 8'h01);
    chk("R10 busy follows socket enable", {7'b0, busyLed}, 8'h01);
    wrReg(3'd5, 8'h03);
    chk("R10 auto-busy gates", {7'b0, busyLed}, 8'h00);
    pulseAccess();
    rdReg(3'd5, d);
    chk("R9 access set", d, 8'h07);
    chk("R10 busy from access", {7'b0, busyLed}, 8'h01);
    wrReg(3'd5, 8'h07);
    rdReg(3'd5, d);
    chk("R9 write one keeps flag", d, 8'h07);
    wrReg(3'd5, 8'h03);
    rdReg(3'd5, d);
    chk("R9 write zero clears flag", d, 8'h03);
    chk("R10 busy after clear", {7'b0, busyLed}, 8'h00);
    wrReg(3'd5, 8'h00);
    pulseAccess();
    rdReg(3'd5, d);
    chk("R9 access set without auto", d, 8'h04);
    chk("R10 busy follows socket off", {7'b0, busyLed}, 8'h00);
    wrReg(3'd5, 8'h00);
  endtask

  task automatic testUnused();
    logic [7:0] d;
    wrReg(3'd6, 8'hFF);
    wrReg(3'd7, 8'hFF);
    wrReg(3'd0, 8'hFF);
    wrReg(3'd4, 8'hFF);
    for (int a = 0; a < 8; a++) begin
      rdReg(3'(a), d);
      chk("R11 stray writes ignored", d, 8'h00);
    end
    chk("R11 pin untouched", {7'b0, irqDriveEn}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testRaw();
    testEdges();
    testMask();
    testOps();
    testIrq();
    testPins();
    testLatched();
    testAccess();
    testUnused();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule